// File: doc/BRIEF.md
# TMDS Three-Lane Deskew Buffer

This block sits after per-lane symbol framing in a TMDS receiver and removes the relative delay between the blue, green and red lanes. Each lane pushes its framed 10-bit symbols into a private 16-entry FIFO. Nothing is stored until all three lanes report that their framing is good. From then on every lane writes one symbol per clock. Reading begins once each FIFO holds a fixed priming level.

Deskew is done at the read side. A lane stops reading when its head symbol is the first control token after a run of pixel symbols, which is the start of blanking. It stays there until every lane presents its own such marker. All three lanes then advance in the same cycle, and from that point the three output symbols come from the same transmit slot. If the skew is too large for the buffers, the FIFOs are flushed and the block goes back to waiting for all lanes to be valid.

Top module: `tmds_lane_deskew`

## Requirements
- R1: After reset `out_valid` and `deskewed` are low.
- R2: While any bit of `lane_valid` is low in the idle state, nothing is written and `out_valid` stays low.
- R3: Once an edge samples all `lane_valid` bits high, each lane writes one symbol on every following edge. `out_valid` rises after PRIME+1 edges (PRIME = 8 by default), and each lane's first output is the symbol it presented at the first write edge.
- R4: The control tokens are 10'b1101010100, 10'b0010101011, 10'b0101010100 and 10'b1010101011. Every other code is a pixel symbol. A lane's marker is a control token at its FIFO head whose predecessor on that lane was a pixel symbol. In the cycle before alignment completes, all three outputs show control tokens.
- R5: A lane at its marker holds its head until every lane is at its marker. Then all lanes advance together, and the three output lanes carry identical symbol streams when the lanes carry the same source delayed by different amounts.
- R6: Once aligned, a control run does not cause further stalls, so every output cycle presents a new symbol.
- R7: Any skew of up to 8 symbol periods between lanes is absorbed and `deskewed` rises.
- R8: A write into a full FIFO that is not read in the same cycle, or a read from an empty FIFO, flushes all FIFOs. The block returns to idle, so `out_valid` falls and `deskewed` stays low when the skew exceeds 8.
- R9: `deskewed` rises at the first alignment event and falls on any flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_valid | input | LANES | Per-lane framing-good flags |
| lane_sym | input | LANES*SYM_W | Framed symbols; lane 0 (blue) in the low bits |
| out_sym | output | LANES*SYM_W | FIFO head symbols, same lane packing |
| out_valid | output | 1 | Read side running; `out_sym` meaningful |
| deskewed | output | 1 | Lanes are symbol-aligned |

## Verification
The bench builds the block with its defaults: three lanes, 16-entry FIFOs and a priming level of 8. This leaves exactly 8 spare entries per FIFO, so lane delays between 0 and 8 align, while a lag of 9 or more fills a stalled FIFO within one blanking start. Random delays from a fixed seed and the directed edge cases at 8 and above 8 both fall inside a few lines of a 52-symbol video line. A delay change in the middle of a line forces the flush path after alignment.

// File: rtl/tmds_deskew_pkg.sv
package tmds_deskew_pkg;

   typedef logic [9:0] tmds_sym_t;

   // the four TMDS control tokens
   localparam tmds_sym_t TOK_C0 = 10'b1101010100;
   localparam tmds_sym_t TOK_C1 = 10'b0010101011;
   localparam tmds_sym_t TOK_C2 = 10'b0101010100;
   localparam tmds_sym_t TOK_C3 = 10'b1010101011;

   typedef enum logic [1:0] {
      DS_IDLE = 2'd0,
      DS_FILL = 2'd1,
      DS_RUN  = 2'd2
   } ds_state_e;

   function automatic logic is_ctl_tok(input tmds_sym_t s);
      return (s == TOK_C0) || (s == TOK_C1) || (s == TOK_C2) || (s == TOK_C3);
   endfunction

endpackage

// File: rtl/dsk_lane_fifo.sv
module dsk_lane_fifo #(
   parameter int W     = 10,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] head,
   output logic         ovf,
   output logic         udf
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("dsk_lane_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          full, empty, wr_ok, rd_ok;

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign ovf   = wr_en && full && !rd_en;
   assign udf   = rd_en && empty;
   assign wr_ok = wr_en && !clr && !ovf;
   assign rd_ok = rd_en && !clr && !udf;
   assign head  = mem[rp];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr_ok) wp <= wp + 1'b1;
         if (rd_ok) rp <= rp + 1'b1;
         cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
      end
   end

   // R8: occupancy never exceeds the storage
   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   // R3: a write without a read grows the occupancy by one
   a_r3_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !rd_ok) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/dsk_lane_marker.sv
module dsk_lane_marker
   import tmds_deskew_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  logic      adv,
   input  tmds_sym_t head,
   output logic      at_mark
);
   logic prev_pix;

   // remembers whether the last symbol taken from this lane was a pixel
   always_ff @(posedge clk) begin
      if (!rst_n || clr) prev_pix <= 1'b0;
      else if (adv)      prev_pix <= !is_ctl_tok(head);
   end

   assign at_mark = prev_pix && is_ctl_tok(head);

endmodule

// File: rtl/dsk_ctrl.sv
module dsk_ctrl
   import tmds_deskew_pkg::*;
#(
   parameter int PRIME = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lanes_ok,
   input  logic fault,
   input  logic align_evt,
   output logic wr_en,
   output logic run,
   output logic deskewed
);
   localparam int FW = $clog2(PRIME + 1);

   ds_state_e     state;
   logic [FW-1:0] fill_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= DS_IDLE;
         fill_cnt <= '0;
         deskewed <= 1'b0;
      end else if (fault) begin
         state    <= DS_IDLE;
         fill_cnt <= '0;
         deskewed <= 1'b0;
      end else begin
         case (state)
            DS_IDLE: if (lanes_ok) begin
               state    <= DS_FILL;
               fill_cnt <= '0;
            end
            DS_FILL: begin
               fill_cnt <= fill_cnt + 1'b1;
               if (fill_cnt == FW'(PRIME - 1)) state <= DS_RUN;
            end
            DS_RUN:  if (align_evt) deskewed <= 1'b1;
            default: state <= DS_IDLE;
         endcase
      end
   end

   assign wr_en = (state != DS_IDLE);
   assign run   = (state == DS_RUN);

   // R2: without all lanes valid the idle state is kept
   a_r2_wait_all: assert property (@(posedge clk) disable iff (!rst_n)
      (state == DS_IDLE && !lanes_ok) |=> !wr_en);

   // R9: a flush drops the aligned flag
   a_r9_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !deskewed);

   // R9: the flag is only ever seen with the read side running
   a_r9_flag_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      deskewed |-> run);

endmodule

// File: rtl/tmds_lane_deskew.sv
module tmds_lane_deskew
   import tmds_deskew_pkg::*;
#(
   parameter int SYM_W = 10,
   parameter int LANES = 3,
   parameter int DEPTH = 16,
   parameter int PRIME = DEPTH / 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LANES-1:0]       lane_valid,
   input  logic [LANES*SYM_W-1:0] lane_sym,
   output logic [LANES*SYM_W-1:0] out_sym,
   output logic                   out_valid,
   output logic                   deskewed
);
   if (SYM_W != $bits(tmds_sym_t)) begin : g_bad_width
      $error("tmds_lane_deskew: SYM_W must match the TMDS symbol width");
   end
   if (PRIME < 1 || PRIME >= DEPTH) begin : g_bad_prime
      $error("tmds_lane_deskew: PRIME must lie in 1..DEPTH-1");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("tmds_lane_deskew: at least two lanes are needed");
   end

   logic             wr_en, run, fault, all_at_mark, align_evt;
   logic [LANES-1:0] at_mark, rd_en, ovf, udf;
   tmds_sym_t        head [LANES];

   assign all_at_mark = &at_mark;
   assign fault       = (|ovf) || (|udf);
   assign align_evt   = run && all_at_mark;
   assign out_valid   = run;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      // a lane parked on its marker only moves when every lane is parked
      assign rd_en[g] = run && (!at_mark[g] || all_at_mark);
      assign out_sym[g*SYM_W +: SYM_W] = head[g];

      dsk_lane_fifo #(
         .W     (SYM_W),
         .DEPTH (DEPTH)
      ) fifo_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (fault),
         .wr_en   (wr_en),
         .wr_data (lane_sym[g*SYM_W +: SYM_W]),
         .rd_en   (rd_en[g]),
         .head    (head[g]),
         .ovf     (ovf[g]),
         .udf     (udf[g])
      );

      dsk_lane_marker mark_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (fault),
         .adv     (rd_en[g] && !fault),
         .head    (head[g]),
         .at_mark (at_mark[g])
      );

      // R5: a waiting lane keeps showing the same head symbol
      a_r5_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
         (run && !fault && at_mark[g] && !all_at_mark) |=> (head[g] == $past(head[g])));

      // R4: only a control token can park a lane
      a_r4_mark_is_ctl: assert property (@(posedge clk) disable iff (!rst_n)
         (run && !rd_en[g]) |-> is_ctl_tok(head[g]));
   end

   dsk_ctrl #(
      .PRIME (PRIME)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .lanes_ok  (&lane_valid),
      .fault     (fault),
      .align_evt (align_evt),
      .wr_en     (wr_en),
      .run       (run),
      .deskewed  (deskewed)
   );

   // R5: an alignment event moves every lane in the same cycle
   a_r5_release_all: assert property (@(posedge clk) disable iff (!rst_n)
      (align_evt && !fault) |-> (rd_en == {LANES{1'b1}}));

endmodule

// File: tb/tmds_lane_deskew_tb_top.sv
module tmds_lane_deskew_tb_top;
   localparam int PRIME = 8;
   localparam int DL    = 40;
   localparam int BL    = 12;
   localparam int P     = DL + BL;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  lane_valid = '0;
   logic [29:0] lane_sym = '0;
   logic [29:0] out_sym;
   logic        out_valid, deskewed;

   int tt = 0;
   int dly [3] = '{0, 0, 0};
   int n_run = 0, n_fail = 0;

   tmds_lane_deskew dut_i (
      .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_sym(lane_sym),
      .out_sym(out_sym), .out_valid(out_valid), .deskewed(deskewed)
   );

   always #5 clk = ~clk;

   function automatic logic [9:0] ctl_code(input int n);
      case (n % 4)
         0: return 10'b1101010100;
         1: return 10'b0010101011;
         2: return 10'b0101010100;
         default: return 10'b1010101011;
      endcase
   endfunction

   function automatic logic is_ctl(input logic [9:0] s);
      return s == ctl_code(0) || s == ctl_code(1) || s == ctl_code(2) || s == ctl_code(3);
   endfunction

   // one video line: DL pixel symbols then BL control tokens
   function automatic logic [9:0] sym_at(input int k);
      if (k < 0) return ctl_code(0);
      if ((k % P) < DL) return {3'b000, 7'(k)};
      return ctl_code(k);
   endfunction

   always @(negedge clk) begin
      tt = tt + 1;
      for (int i = 0; i < 3; i++) lane_sym[i*10 +: 10] = sym_at(tt - dly[i]);
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [9:0] lane_out(input int i);
      return out_sym[i*10 +: 10];
   endfunction

   task automatic do_reset();
      lane_valid = '0;
      rst_n = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic start_at_mid_line();
      do step(); while ((tt % P) != 15);
   endtask

   // bring the lanes up and check priming latency and first symbols (R3)
   task automatic bring_up();
      int t0;
      lane_valid = 3'b111;
      t0 = tt;
      repeat (PRIME) step();
      check(out_valid == 1'b0, "R3 out_valid low while priming", int'(out_valid), 0);
      step();
      check(out_valid == 1'b1, "R3 out_valid after PRIME+1 edges", int'(out_valid), 1);
      for (int i = 0; i < 3; i++)
         check(lane_out(i) == sym_at(t0 + 1 - dly[i]), "R3 first symbol of lane",
               int'(lane_out(i)), int'(sym_at(t0 + 1 - dly[i])));
   endtask

   // wait for alignment, then check the aligned streams
   task automatic good_case(input int d0, input int d1, input int d2);
      logic [29:0] last;
      bit          seen;
      int          bad_eq, bad_rep, bad_v;
      do_reset();
      dly[0] = d0; dly[1] = d1; dly[2] = d2;
      start_at_mid_line();
      bring_up();
      seen = 0;
      last = out_sym;
      for (int c = 0; c < 3 * P && !seen; c++) begin
         last = out_sym;
         step();
         if (deskewed) seen = 1;
      end
      check(seen, $sformatf("R7 R9 deskewed rises for skew %0d/%0d/%0d", d0, d1, d2), int'(seen), 1);
      check(is_ctl(last[9:0]) && is_ctl(last[19:10]) && is_ctl(last[29:20]),
            "R4 all lanes show control token before release", int'(last[9:0]), int'(ctl_code(0)));
      bad_eq = 0; bad_rep = 0; bad_v = 0;
      last = out_sym;
      for (int c = 0; c < 2 * P; c++) begin
         step();
         if (!(lane_out(0) == lane_out(1) && lane_out(1) == lane_out(2))) bad_eq++;
         if (lane_out(0) == last[9:0]) bad_rep++;
         if (!out_valid || !deskewed) bad_v++;
         last = out_sym;
      end
      check(bad_eq == 0, "R5 lanes carry identical aligned streams", bad_eq, 0);
      check(bad_rep == 0, "R6 no stalls once aligned", bad_rep, 0);
      check(bad_v == 0, "R9 deskewed and out_valid stay high", bad_v, 0);
   endtask

   task automatic over_case(input int d0, input int d1, input int d2);
      bit was_v, dropped, ever_dsk;
      do_reset();
      dly[0] = d0; dly[1] = d1; dly[2] = d2;
      start_at_mid_line();
      lane_valid = 3'b111;
      was_v = 0; dropped = 0; ever_dsk = 0;
      for (int c = 0; c < 3 * P; c++) begin
         step();
         if (out_valid) was_v = 1;
         else if (was_v) dropped = 1;
         if (deskewed) ever_dsk = 1;
      end
      check(dropped, $sformatf("R8 flush on skew %0d/%0d/%0d", d0, d1, d2), int'(dropped), 1);
      check(!ever_dsk, "R8 no alignment beyond 8 symbols of skew", int'(ever_dsk), 0);
   endtask

   initial begin
      bit          any_v;
      bit          fell, low_seen;
      logic [2:0]  partial;
      void'($urandom(32'd4711));
      step();
      check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
      check(deskewed == 1'b0, "R1 deskewed after reset", int'(deskewed), 0);
      rst_n = 1'b1;

      // R2: two of three lanes valid, random choice of the missing one
      partial = 3'b111 & ~(3'b001 << ($urandom % 3));
      lane_valid = partial;
      any_v = 0;
      for (int c = 0; c < 40; c++) begin
         step();
         if (out_valid) any_v = 1;
      end
      check(!any_v, "R2 no output without all lanes valid", int'(any_v), 0);

      good_case(0, 0, 0);
      good_case(0, 8, 3);
      good_case(8, 0, 8);
      for (int r = 0; r < 3; r++)
         good_case(int'($urandom % 9), int'($urandom % 9), int'($urandom % 9));
      over_case(0, 9, 4);
      over_case(12, 1, 3);

      // R9: aligned, then lane 1 jumps back 12 symbols in mid line
      good_case(2, 2, 2);
      do step(); while ((tt % P) != 30);
      dly[1] = 14;
      fell = 0; low_seen = 0;
      for (int c = 0; c < 2 * P; c++) begin
         step();
         if (!deskewed) fell = 1;
         if (!out_valid) low_seen = 1;
      end
      check(fell, "R9 deskewed falls on flush", int'(fell), 1);
      check(low_seen, "R8 flush returns block to idle", int'(low_seen), 1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (40000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule